// File: doc/BRIEF.md
# Fault-Injectable Bit RAM

This block is a small synchronous single-port RAM of one-bit cells, arranged as rows and columns (default 8 x 8 = 64 cells). The cell address is the row index concatenated above the column index. It acts as a stand-in for a memory macro when a memory test controller is being brought up. Through a fault configuration port it can be made to behave as if a single classic cell defect were present. Every fault has a victim cell, and coupling faults also name an aggressor cell. A test controller run against it should then report a mismatch where the defect lies.

The fault configuration is latched only in idle cycles, when no read and no write is requested. It therefore stays fixed during a run of accesses. The fault rules work on the stored cell values. A corrupted write, a coupled change or a forced value is held in the array until it is overwritten, and any later read shows it.

Top module: `fault_ram_emu`

## Requirements
- R1: After reset every cell holds 0, `rd_data` is 0 and no fault rule is active.
- R2: A read (`rd_en`=1, `wr_en`=0) updates `rd_data` at the next clock edge. `rd_data` holds its value in every other cycle. When `rd_en` and `wr_en` are both 1, only the write is performed.
- R3: The `flt_*` inputs are latched only in cycles with `rd_en`=0 and `wr_en`=0. A rule applies only when the latched `flt_en` is 1. The `flt_kind` codes are: 0 none, 1 stuck-at-0, 2 stuck-at-1, 3 rising transition, 4 falling transition, 5 inversion coupling, 6 idempotent coupling, 7 state coupling, 8 read disturb. Codes 9 to 15 select no rule.
- R4: Stuck-at-0: the victim cell reads 0 whatever value is written to it.
- R5: Stuck-at-1: the victim cell reads 1 whatever value is written to it, including right after the fault is enabled.
- R6: Rising transition: a write of 1 to a victim holding 0 leaves it at 0. Writing 1 over 1, and writing 0, work normally.
- R7: Falling transition: a write of 0 to a victim holding 1 leaves it at 1.
- R8: Inversion coupling: a write that changes the aggressor to the value `flt_pol` (1 = rising edge, 0 = falling edge) inverts the victim. Writes that cause no change, or a change of the other direction, leave the victim alone.
- R9: Idempotent coupling: a write that changes the aggressor to `flt_pol` sets the victim to `flt_force`.
- R10: State coupling: while the aggressor holds `flt_pol`, the victim is held at `flt_force`, and writes to the victim have no effect. All four pol/force pairs are supported. Once the aggressor leaves that state, the victim can be written again.
- R11: Read disturb: each read of the victim returns the value stored before the read, and then inverts the stored value. The next read shows the inverted value. Reads of other cells are unaffected.
- R12: With the latched `flt_en` at 0, or with an unused kind code, the RAM behaves as a plain memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 6 | Cell address {row, column} |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| wr_data | input | 1 | Bit to write |
| rd_data | output | 1 | Registered read bit |
| flt_en | input | 1 | Fault enable |
| flt_kind | input | 4 | Fault kind code |
| flt_victim | input | 6 | Victim cell address |
| flt_aggr | input | 6 | Aggressor cell address |
| flt_pol | input | 1 | Aggressor edge direction or aggressor state |
| flt_force | input | 1 | Value forced into the victim |

## Verification
A wrong stored cell is only visible through `rd_data`, and only one edge after that cell is read. The bench therefore follows each fault stimulus with a read of the victim. In most cases it also reads a neighbour or a non-matching case, so that an over-eager rule is caught as well. For a missed or misdirected coupling event, a wrong disturb flip, or a configuration latched while busy, the wrong value shows on the first read that follows, one clock after it is issued. Back-to-back reads of the disturbed victim expose a flip that is missing or doubled in alternating cycles.

// File: rtl/fault_ram_pkg.sv
package fault_ram_pkg;

  typedef enum logic [3:0] {
    FK_NONE       = 4'd0,
    FK_SA0        = 4'd1,
    FK_SA1        = 4'd2,
    FK_TF_UP      = 4'd3,
    FK_TF_DN      = 4'd4,
    FK_CF_INV     = 4'd5,
    FK_CF_IDEM    = 4'd6,
    FK_CF_STATE   = 4'd7,
    FK_RD_DISTURB = 4'd8
  } fault_kind_e;

  // Value a victim write actually leaves in the cell under a transition rule.
  function automatic logic victim_write_val(input logic [3:0] kind,
                                            input logic old_v,
                                            input logic din);
    logic res;
    res = din;
    if (kind == FK_TF_UP && !old_v && din) res = 1'b0;
    if (kind == FK_TF_DN && old_v && !din) res = 1'b1;
    return res;
  endfunction

  // True when a write moves the aggressor from old_v to din and ends at pol.
  function automatic logic aggr_edge_hit(input logic old_v,
                                         input logic din,
                                         input logic pol);
    return (old_v != din) && (din == pol);
  endfunction

endpackage

// File: rtl/fault_ram_cfg.sv
module fault_ram_cfg #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              en_in,
  input  logic [3:0]        kind_in,
  input  logic [ADDR_W-1:0] victim_in,
  input  logic [ADDR_W-1:0] aggr_in,
  input  logic              pol_in,
  input  logic              force_in,
  output logic              flt_on,
  output logic [3:0]        kind_q,
  output logic [ADDR_W-1:0] victim_q,
  output logic [ADDR_W-1:0] aggr_q,
  output logic              pol_q,
  output logic              force_q
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      kind_q   <= 4'd0;
      victim_q <= '0;
      aggr_q   <= '0;
      pol_q    <= 1'b0;
      force_q  <= 1'b0;
    end else if (sample) begin
      en_q     <= en_in;
      kind_q   <= kind_in;
      victim_q <= victim_in;
      aggr_q   <= aggr_in;
      pol_q    <= pol_in;
      force_q  <= force_in;
    end
  end

  assign flt_on = en_q && (kind_q != 4'd0);
endmodule

// File: rtl/fault_ram_store.sv
module fault_ram_store
  import fault_ram_pkg::*;
#(
  parameter int CELLS  = 64,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_fire,
  input  logic              wr_data,
  input  logic              flt_on,
  input  logic [3:0]        kind,
  input  logic [ADDR_W-1:0] victim,
  input  logic [ADDR_W-1:0] aggr,
  input  logic              pol,
  input  logic              force_v,
  output logic [CELLS-1:0]  mem_q,
  output logic              cpl_fire,
  output logic              disturb_fire,
  output logic              tf_block
);
  logic [CELLS-1:0] mem_d;
  logic             vic_wval;
  logic             aggr_nxt;
  logic             is_coupling;

  assign vic_wval    = victim_write_val(kind, mem_q[victim], wr_data);
  assign aggr_nxt    = (wr_en && addr == aggr) ? wr_data : mem_q[aggr];
  assign is_coupling = (kind == FK_CF_INV) || (kind == FK_CF_IDEM);

  assign cpl_fire = flt_on && is_coupling && wr_en && (addr == aggr) &&
                    (aggr != victim) && aggr_edge_hit(mem_q[aggr], wr_data, pol);
  assign disturb_fire = flt_on && (kind == FK_RD_DISTURB) && rd_fire &&
                        (addr == victim);
  assign tf_block = flt_on && wr_en && (addr == victim) &&
                    (kind == FK_TF_UP || kind == FK_TF_DN) && (vic_wval != wr_data);

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    logic is_vic;
    logic nxt;
    assign is_vic = flt_on && (victim == ADDR_W'(i));
    always_comb begin
      nxt = mem_q[i];
      if (wr_en && addr == ADDR_W'(i)) nxt = is_vic ? vic_wval : wr_data;
      if (is_vic) begin
        if (cpl_fire) nxt = (kind == FK_CF_INV) ? ~mem_q[i] : force_v;
        if (disturb_fire) nxt = ~mem_q[i];
        case (kind)
          FK_SA0:      nxt = 1'b0;
          FK_SA1:      nxt = 1'b1;
          FK_CF_STATE: if (aggr_nxt == pol && aggr != victim) nxt = force_v;
          default:     ;
        endcase
      end
    end
    assign mem_d[i] = nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mem_q <= '0;
    else        mem_q <= mem_d;
  end
endmodule

// File: rtl/fault_ram_rdport.sv
module fault_ram_rdport (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_fire,
  input  logic rd_bit,
  output logic rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n)       rd_data <= 1'b0;
    else if (rd_fire) rd_data <= rd_bit;
  end
endmodule

// File: rtl/fault_ram_emu.sv
module fault_ram_emu #(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       wr_data,
  output logic       rd_data,
  input  logic       flt_en,
  input  logic [3:0] flt_kind,
  input  logic [5:0] flt_victim,
  input  logic [5:0] flt_aggr,
  input  logic       flt_pol,
  input  logic       flt_force
);
  localparam int CELLS  = ROWS * COLS;
  localparam int ADDR_W = $clog2(CELLS);

  logic              rd_fire;
  logic              cfg_sample;
  logic              flt_on;
  logic [3:0]        kind_q;
  logic [ADDR_W-1:0] victim_q;
  logic [ADDR_W-1:0] aggr_q;
  logic              pol_q;
  logic              force_q;
  logic [CELLS-1:0]  mem_q;
  logic              cpl_fire;
  logic              disturb_fire;
  logic              tf_block;
  logic              victim_bit;

  assign rd_fire    = rd_en && !wr_en;
  assign cfg_sample = !rd_en && !wr_en;

  fault_ram_cfg #(.ADDR_W(ADDR_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .sample(cfg_sample),
    .en_in(flt_en), .kind_in(flt_kind), .victim_in(flt_victim),
    .aggr_in(flt_aggr), .pol_in(flt_pol), .force_in(flt_force),
    .flt_on(flt_on), .kind_q(kind_q), .victim_q(victim_q),
    .aggr_q(aggr_q), .pol_q(pol_q), .force_q(force_q)
  );

  fault_ram_store #(.CELLS(CELLS), .ADDR_W(ADDR_W)) store_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .rd_fire(rd_fire), .wr_data(wr_data), .flt_on(flt_on),
    .kind(kind_q), .victim(victim_q), .aggr(aggr_q), .pol(pol_q),
    .force_v(force_q), .mem_q(mem_q), .cpl_fire(cpl_fire),
    .disturb_fire(disturb_fire), .tf_block(tf_block)
  );

  fault_ram_rdport rdport_i (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire),
    .rd_bit(mem_q[addr]), .rd_data(rd_data)
  );

  assign victim_bit = mem_q[victim_q];
endmodule

// File: rtl/fault_ram_emu_chk.sv
module fault_ram_emu_chk
  import fault_ram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_data,
  input logic              flt_on,
  input logic [3:0]        kind_q,
  input logic [ADDR_W-1:0] victim_q,
  input logic              force_q,
  input logic              victim_bit,
  input logic              cpl_fire,
  input logic              disturb_fire,
  input logic              tf_block
);
  a_r2_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !wr_en) |=> $stable(rd_data));

  a_r3_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) |=> ($stable(kind_q) && $stable(victim_q) && $stable(flt_on)));

  a_r4_sa0_read: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_on && kind_q == FK_SA0 && rd_en && !wr_en && addr == victim_q) |=> !rd_data);

  a_r5_sa1_read: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_on && kind_q == FK_SA1 && rd_en && !wr_en && addr == victim_q) |=> rd_data);

  a_r6_tf_up_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_block && kind_q == FK_TF_UP) |=> !victim_bit);

  a_r7_tf_dn_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_block && kind_q == FK_TF_DN) |=> victim_bit);

  a_r8_cfin_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_fire && kind_q == FK_CF_INV) |=> (victim_bit != $past(victim_bit)));

  a_r9_cfid_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_fire && kind_q == FK_CF_IDEM) |=> (victim_bit == force_q));

  a_r11_disturb: assert property (@(posedge clk) disable iff (!rst_n)
    disturb_fire |=> ((victim_bit != $past(victim_bit)) && (rd_data == $past(victim_bit))));
endmodule

bind fault_ram_emu fault_ram_emu_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rd_data(rd_data), .flt_on(flt_on), .kind_q(kind_q), .victim_q(victim_q),
  .force_q(force_q), .victim_bit(victim_bit), .cpl_fire(cpl_fire),
  .disturb_fire(disturb_fire), .tf_block(tf_block)
);

// File: tb/fault_ram_emu_tb_top.sv
`timescale 1ns/1ps
module fault_ram_emu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic       wr_data = 1'b0;
  logic       rd_data;
  logic       flt_en = 1'b0;
  logic [3:0] flt_kind = '0;
  logic [5:0] flt_victim = '0;
  logic [5:0] flt_aggr = '0;
  logic       flt_pol = 1'b0;
  logic       flt_force = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic  exp;
    string tag;
  } exp_t;
  exp_t sb_q[$];
  logic rd_seen = 1'b0;

  always #2 clk = ~clk;

  fault_ram_emu dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .flt_en(flt_en), .flt_kind(flt_kind),
    .flt_victim(flt_victim), .flt_aggr(flt_aggr), .flt_pol(flt_pol),
    .flt_force(flt_force)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rd_data=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor: a read issued in cycle N is compared at the negedge after edge N
  always @(posedge clk) rd_seen <= rst_n && rd_en && !wr_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2: unexpected read result %0b expected none", rd_data);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, rd_data, e.exp);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input int a, input logic d);
    @(negedge clk);
    addr = 6'(a); wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic exp, input string tag);
    exp_t e;
    @(negedge clk);
    addr = 6'(a); wr_en = 1'b0; rd_en = 1'b1;
    e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic cfg(input logic en, input int kind, input int vic, input int ag,
                     input logic pol, input logic frc);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    flt_en = en; flt_kind = 4'(kind); flt_victim = 6'(vic);
    flt_aggr = 6'(ag); flt_pol = pol; flt_force = frc;
    idle(); idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, got running expected done");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset rd_data", rd_data, 1'b0);
    rd(7, 1'b0, "R1 cell cleared");
    rd(40, 1'b0, "R1 cell cleared");

    // R2 plain access, latency, hold, write wins
    wr(7, 1'b1);
    rd(7, 1'b1, "R2 read after write");
    idle(); idle(); idle();
    check("R2 rd_data held while idle", rd_data, 1'b1);
    @(negedge clk);
    addr = 6'd7; wr_data = 1'b0; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R2 read ignored when writing", rd_data, 1'b1);
    rd(7, 1'b0, "R2 write performed");

    // R3 fault inputs ignored while busy
    @(negedge clk);
    addr = 6'd3; wr_data = 1'b1; wr_en = 1'b1; rd_en = 1'b0;
    flt_en = 1'b1; flt_kind = 4'd1; flt_victim = 6'd3;
    @(negedge clk);
    flt_en = 1'b0; flt_kind = 4'd0;
    addr = 6'd3; wr_en = 1'b0; rd_en = 1'b1;
    begin exp_t e; e.exp = 1'b1; e.tag = "R3 config not latched during access"; sb_q.push_back(e); end
    rd(3, 1'b1, "R3 config not latched later");

    // R4 stuck-at-0
    cfg(1'b1, 1, 10, 0, 1'b0, 1'b0);
    wr(10, 1'b1);
    rd(10, 1'b0, "R4 stuck-at-0 victim");
    wr(11, 1'b1);
    rd(11, 1'b1, "R4 neighbour normal");

    // R5 stuck-at-1
    cfg(1'b1, 2, 12, 0, 1'b0, 1'b0);
    rd(12, 1'b1, "R5 stuck-at-1 at enable");
    wr(12, 1'b0);
    rd(12, 1'b1, "R5 stuck-at-1 after write 0");

    // R6 rising transition
    cfg(1'b1, 3, 14, 0, 1'b0, 1'b0);
    wr(14, 1'b1);
    rd(14, 1'b0, "R6 rise blocked");
    cfg(1'b0, 0, 0, 0, 1'b0, 1'b0);
    wr(14, 1'b1);
    cfg(1'b1, 3, 14, 0, 1'b0, 1'b0);
    wr(14, 1'b1);
    rd(14, 1'b1, "R6 one over one kept");
    wr(14, 1'b0);
    rd(14, 1'b0, "R6 fall works");

    // R7 falling transition
    cfg(1'b0, 0, 0, 0, 1'b0, 1'b0);
    wr(15, 1'b1);
    cfg(1'b1, 4, 15, 0, 1'b0, 1'b0);
    wr(15, 1'b0);
    rd(15, 1'b1, "R7 fall blocked");

    // R8 inversion coupling
    cfg(1'b1, 5, 20, 21, 1'b1, 1'b0);
    wr(21, 1'b1);
    rd(20, 1'b1, "R8 rising edge inverts");
    wr(21, 1'b1);
    rd(20, 1'b1, "R8 no change no effect");
    wr(21, 1'b0);
    rd(20, 1'b1, "R8 other edge no effect");
    wr(21, 1'b1);
    rd(20, 1'b0, "R8 second rising inverts");
    cfg(1'b1, 5, 20, 21, 1'b0, 1'b0);
    wr(21, 1'b0);
    rd(20, 1'b1, "R8 falling edge inverts");

    // R9 idempotent coupling
    cfg(1'b1, 6, 22, 23, 1'b1, 1'b1);
    wr(23, 1'b1);
    rd(22, 1'b1, "R9 rise forces 1");
    cfg(1'b1, 6, 22, 23, 1'b0, 1'b0);
    wr(23, 1'b0);
    rd(22, 1'b0, "R9 fall forces 0");

    // R10 state coupling, four pol/force pairs (victim 24, aggressor 25)
    cfg(1'b1, 7, 24, 25, 1'b0, 1'b1);
    rd(24, 1'b1, "R10 aggr0 forces 1");
    wr(24, 1'b0);
    rd(24, 1'b1, "R10 victim write ignored");
    wr(25, 1'b1);
    wr(24, 1'b0);
    rd(24, 1'b0, "R10 released after aggr change");
    cfg(1'b1, 7, 24, 25, 1'b1, 1'b1);
    rd(24, 1'b1, "R10 aggr1 forces 1");
    wr(25, 1'b0);
    wr(24, 1'b0);
    rd(24, 1'b0, "R10 released aggr1");
    cfg(1'b0, 0, 0, 0, 1'b0, 1'b0);
    wr(24, 1'b1);
    cfg(1'b1, 7, 24, 25, 1'b0, 1'b0);
    rd(24, 1'b0, "R10 aggr0 forces 0");
    cfg(1'b0, 0, 0, 0, 1'b0, 1'b0);
    wr(25, 1'b1);
    wr(24, 1'b1);
    cfg(1'b1, 7, 24, 25, 1'b1, 1'b0);
    rd(24, 1'b0, "R10 aggr1 forces 0");

    // R11 read disturb
    cfg(1'b0, 0, 0, 0, 1'b0, 1'b0);
    wr(30, 1'b1);
    cfg(1'b1, 8, 30, 0, 1'b0, 1'b0);
    rd(30, 1'b1, "R11 first read old value");
    rd(30, 1'b0, "R11 flipped value seen");
    rd(30, 1'b1, "R11 flipped back");
    rd(31, 1'b0, "R11 other cell stable");
    rd(31, 1'b0, "R11 other cell stable again");

    // R12 disabled or unused code
    cfg(1'b0, 2, 40, 0, 1'b0, 1'b0);
    rd(40, 1'b0, "R12 disabled stuck-at-1");
    cfg(1'b1, 9, 41, 0, 1'b0, 1'b0);
    wr(41, 1'b1);
    rd(41, 1'b1, "R12 unused code plain");

    idle(); idle(); idle();
    if (sb_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R2: %0d reads unanswered expected 0", sb_q.size());
    end
    report();
  end
endmodule